// File: doc/BRIEF.md
# Integrating Light Converter Conversion Sequencer

This block sequences an integrating, frequency-output light converter. The analog front end delivers one pulse stream per photodiode, and a separate oscillator supplies a tick. Each clock cycle carries at most one pulse per stream and at most one tick. The block takes an 8-bit command, presented as a byte with a one-cycle strobe. From it the block picks the action: sleep, clear, a timing class, and a source. The source is diode 1, diode 2, or diode 1 minus diode 2.

In each integration window the block counts the pulses of the selected source and the oscillator ticks. When the window closes, it publishes a DATA_W-bit result and a DATA_W-bit tick count, and raises a one-cycle done strobe. A self-timed window closes after exactly 2^SELF_LOG2 ticks. An externally bounded window closes when the next external-timing command arrives. Differential conversion takes two windows: the diode 2 window first, then the diode 1 window. It publishes the wrapped difference as a signed two's-complement value. The published values hold until the next conversion completes.

Top module: `conv_seq_top`

## Requirements
- R1: After reset, conv_result and conv_cycles are zero, conv_done, conv_ovf and conv_off are low, and no conversion runs until a command arrives.
- R2: Command 00h (diode 1) or 04h (diode 2) starts self-timed conversions. The window begins in the cycle after the command cycle. It ends in the cycle that carries the 2^SELF_LOG2-th tick of that window. In the following cycle conv_done is high for one cycle, conv_result holds the count of selected-source pulses over the window, and conv_cycles holds 2^SELF_LOG2. The next window starts at once, and this repeats.
- R3: Command 08h runs self-timed differential conversion. A full window counts diode 2 pulses, then the next full window counts diode 1 pulses. Only the end of the second window publishes. The result is (diode 1 count − diode 2 count) modulo 2^DATA_W, and conv_cycles is 2^SELF_LOG2.
- R4: Commands 30h (diode 1), 34h (diode 2) and 38h (difference) use externally bounded windows. An external command that arrives while no external window is open only opens a window. Each later external command closes the open window; the command cycle itself counts toward that window. The result is judged by the source in effect during the window. conv_cycles holds the ticks counted in the window, and the next window opens at once.
- R5: Under 38h, consecutive external windows alternate: the diode 2 phase first, then the diode 1 phase. The close of a diode 2 phase publishes nothing. The close of a diode 1 phase publishes diode 1 minus diode 2, modulo 2^DATA_W, with that phase's tick count.
- R6: Pulse and tick counts saturate at 2^DATA_W−1. When either count would pass that value, conv_ovf rises and stays high until the next window starts. Any recognised command starts a new window and clears conv_ovf.
- R7: Command 8Ch stops conversion and raises conv_off. While conv_off is high, conv_done stays low and the published values do not change. Any recognised conversion command lowers conv_off and starts that conversion fresh.
- R8: Command 0Ch sets conv_result and conv_cycles to zero and lowers conv_off. No conversion runs after it, so conv_done stays low until a conversion command arrives.
- R9: Writing a self-timed command again, even the same one, discards the open window without publishing. The next publication comes a full window after the rewrite.
- R10: Byte values other than 00h, 04h, 08h, 30h, 34h, 38h, 0Ch and 8Ch have no effect. They do not restart the window, and the running conversion publishes on its original schedule.
- R11: Between done strobes, conv_result and conv_cycles keep their previous values. Only a clear command can change them outside a done strobe.
- R12: If a recognised command arrives in the cycle that would end a self-timed window, the command wins. Nothing is published, and the new command's window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | One-cycle command strobe |
| cmd_byte | input | 8 | Command code |
| osc_tick | input | 1 | Oscillator cycle marker, at most one per clock |
| pulse_d1 | input | 1 | Diode 1 converter pulse |
| pulse_d2 | input | 1 | Diode 2 converter pulse |
| conv_result | output | DATA_W | Latest published result; signed in differential mode |
| conv_cycles | output | DATA_W | Ticks in the window that produced the result |
| conv_done | output | 1 | High for one cycle when new values are published |
| conv_ovf | output | 1 | Sticky saturation flag for the open window |
| conv_off | output | 1 | Converter is powered down |

## Verification
The assertions assume that each command is a single-cycle strobe whose byte is stable while the strobe is high. They also assume the pulse and tick inputs are already synchronous to clk, with at most one event per cycle. The bench drives every input at the falling edge from fixed periodic patterns, and it changes a pattern only between scenarios, never inside a window. It therefore works out each window's pulse and tick totals by counting pattern hits over cycle ranges. A deliberately idle stretch while powered down checks that the held results stay put.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        SRC_D1   = 2'd0,
        SRC_D2   = 2'd1,
        SRC_DIFF = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SLEEP,
        OP_CLEAR,
        OP_SELF,
        OP_EXT
    } op_e;

    typedef enum logic [1:0] {
        RUN_IDLE,
        RUN_SELF,
        RUN_EXT
    } run_e;

    typedef struct packed {
        op_e  op;
        src_e src;
    } cmd_t;

    localparam logic [7:0] CODE_SLEEP = 8'h8C;
    localparam logic [7:0] CODE_CLEAR = 8'h0C;

    // bits[5:4]: 00 self-timed, 11 externally bounded; bits[3:2]: source
    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.op  = OP_NONE;
        c.src = SRC_D1;
        if (b == CODE_SLEEP) begin
            c.op = OP_SLEEP;
        end else if (b == CODE_CLEAR) begin
            c.op = OP_CLEAR;
        end else if (b[7:6] == 2'b00 && b[1:0] == 2'b00 && b[3:2] != 2'b11 &&
                     (b[5:4] == 2'b00 || b[5:4] == 2'b11)) begin
            c.op  = (b[5:4] == 2'b11) ? OP_EXT : OP_SELF;
            c.src = src_e'(b[3:2]);
        end
        return c;
    endfunction

    function automatic logic is_known(input logic [7:0] b);
        cmd_t c;
        c = decode_cmd(b);
        return c.op != OP_NONE;
    endfunction

endpackage

// File: rtl/conv_sat_ctr.sv
module conv_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] nxt,
    output logic         hit
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    assign hit = inc && (cnt_q == TOP);
    assign nxt = (inc && cnt_q != TOP) ? cnt_q + 1'b1 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else            cnt_q <= nxt;
    end
endmodule

// File: rtl/conv_result_reg.sv
module conv_result_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         zero,
    input  logic         load,
    input  logic [W-1:0] res_in,
    input  logic [W-1:0] cyc_in,
    output logic [W-1:0] res,
    output logic [W-1:0] cyc,
    output logic         done
);
    always_ff @(posedge clk) begin
        if (rst || zero) begin
            res  <= '0;
            cyc  <= '0;
            done <= 1'b0;
        end else begin
            done <= load;
            if (load) begin
                res <= res_in;
                cyc <= cyc_in;
            end
        end
    end
endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top
    import conv_seq_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SELF_LOG2 = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_stb,
    input  logic [7:0]        cmd_byte,
    input  logic              osc_tick,
    input  logic              pulse_d1,
    input  logic              pulse_d2,
    output logic [DATA_W-1:0] conv_result,
    output logic [DATA_W-1:0] conv_cycles,
    output logic              conv_done,
    output logic              conv_ovf,
    output logic              conv_off
);
    localparam int NCTR = 2;     // index 0: pulses, index 1: ticks
    localparam logic [DATA_W-1:0] SELF_LEN = DATA_W'(1) << SELF_LOG2;

    cmd_t              cmd;
    logic              cmd_ok;
    run_e              run_q;
    src_e              src_q;
    logic              ph_d1_q;
    logic              off_q;
    logic              ovf_q;
    logic [DATA_W-1:0] hold_q;
    logic              sel_pulse;
    logic              running;
    logic [NCTR-1:0]   inc_v;
    logic [NCTR-1:0]   hit_v;
    logic [DATA_W-1:0] nxt_v [NCTR];
    logic              self_end;
    logic              ext_end;
    logic              win_end;
    logic              last_phase;
    logic              publish;
    logic              win_clr;
    logic              zero_out;
    logic [DATA_W-1:0] pub_val;
    logic              self_active;

    assign cmd    = decode_cmd(cmd_byte);
    assign cmd_ok = cmd_stb && (cmd.op != OP_NONE);

    always_comb begin
        case (src_q)
            SRC_D1:   sel_pulse = pulse_d1;
            SRC_D2:   sel_pulse = pulse_d2;
            default:  sel_pulse = ph_d1_q ? pulse_d1 : pulse_d2;
        endcase
    end

    assign running  = (run_q != RUN_IDLE);
    assign inc_v[0] = running && sel_pulse;
    assign inc_v[1] = running && osc_tick;

    generate
        for (genvar g = 0; g < NCTR; g++) begin : g_ctr
            conv_sat_ctr #(.W(DATA_W)) ctr_i (
                .clk (clk),
                .rst (rst),
                .clr (win_clr),
                .inc (inc_v[g]),
                .nxt (nxt_v[g]),
                .hit (hit_v[g])
            );
        end
    endgenerate

    assign self_end   = (run_q == RUN_SELF) && osc_tick && (nxt_v[1] == SELF_LEN);
    assign ext_end    = cmd_ok && (cmd.op == OP_EXT) && (run_q == RUN_EXT);
    assign win_end    = cmd_ok ? ext_end : self_end;
    assign last_phase = (src_q != SRC_DIFF) || ph_d1_q;
    assign publish    = win_end && last_phase;
    assign pub_val    = (src_q == SRC_DIFF) ? nxt_v[0] - hold_q : nxt_v[0];
    assign win_clr    = cmd_ok || self_end;
    assign zero_out   = cmd_ok && (cmd.op == OP_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= RUN_IDLE;
            src_q   <= SRC_D1;
            ph_d1_q <= 1'b0;
            off_q   <= 1'b0;
            ovf_q   <= 1'b0;
            hold_q  <= '0;
        end else begin
            ovf_q <= win_clr ? 1'b0 : (ovf_q | (|hit_v));
            if (win_end && !last_phase) hold_q <= nxt_v[0];
            if (cmd_ok) begin
                ph_d1_q <= ext_end && (src_q == SRC_DIFF) && !ph_d1_q &&
                           (cmd.src == SRC_DIFF);
                src_q   <= cmd.src;
                off_q   <= (cmd.op == OP_SLEEP);
                case (cmd.op)
                    OP_SELF: run_q <= RUN_SELF;
                    OP_EXT:  run_q <= RUN_EXT;
                    default: run_q <= RUN_IDLE;
                endcase
            end else if (self_end && src_q == SRC_DIFF) begin
                ph_d1_q <= !ph_d1_q;
            end
        end
    end

    conv_result_reg #(.W(DATA_W)) res_i (
        .clk    (clk),
        .rst    (rst),
        .zero   (zero_out),
        .load   (publish),
        .res_in (pub_val),
        .cyc_in (nxt_v[1]),
        .res    (conv_result),
        .cyc    (conv_cycles),
        .done   (conv_done)
    );

    assign conv_ovf    = ovf_q;
    assign conv_off    = off_q;
    assign self_active = (run_q == RUN_SELF);

endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk
    import conv_seq_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SELF_LOG2 = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_stb,
    input logic [7:0]        cmd_byte,
    input logic [DATA_W-1:0] conv_result,
    input logic [DATA_W-1:0] conv_cycles,
    input logic              conv_done,
    input logic              conv_ovf,
    input logic              conv_off,
    input logic              run_self
);
    localparam logic [DATA_W-1:0] SELF_LEN = DATA_W'(1) << SELF_LOG2;

    a_r7_off_no_done: assert property (@(posedge clk) disable iff (rst)
        conv_off |-> !conv_done);

    a_r7_off_hold: assert property (@(posedge clk) disable iff (rst)
        (conv_off && $past(conv_off)) |-> ($stable(conv_result) && $stable(conv_cycles)));

    a_r11_hold_result: assert property (@(posedge clk) disable iff (rst)
        (!conv_done && !$past(cmd_stb && cmd_byte == CODE_CLEAR))
        |-> ($stable(conv_result) && $stable(conv_cycles)));

    a_r2_self_cycles: assert property (@(posedge clk) disable iff (rst)
        (conv_done && $past(run_self)) |-> (conv_cycles == SELF_LEN));

    a_r6_ovf_clear: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_stb && is_known(cmd_byte)) |-> !conv_ovf);
endmodule

bind conv_seq_top conv_seq_chk #(.DATA_W(DATA_W), .SELF_LOG2(SELF_LOG2)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_stb     (cmd_stb),
    .cmd_byte    (cmd_byte),
    .conv_result (conv_result),
    .conv_cycles (conv_cycles),
    .conv_done   (conv_done),
    .conv_ovf    (conv_ovf),
    .conv_off    (conv_off),
    .run_self    (self_active)
);

// File: tb/conv_seq_top_tb_top.sv
`timescale 1ns/1ps
module conv_seq_top_tb_top;
    localparam int DW   = 8;
    localparam int SL2  = 4;
    localparam int WIN  = 1 << SL2;
    localparam int MASK = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_stb = 1'b0;
    logic [7:0]    cmd_byte = 8'h00;
    logic          osc_tick = 1'b0;
    logic          pulse_d1 = 1'b0;
    logic          pulse_d2 = 1'b0;
    logic [DW-1:0] conv_result;
    logic [DW-1:0] conv_cycles;
    logic          conv_done;
    logic          conv_ovf;
    logic          conv_off;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_i = 0;
    int last_idx = 0;
    int tp = 2, ap = 3, bp = 5;

    always #10 clk = ~clk;

    conv_seq_top #(.DATA_W(DW), .SELF_LOG2(SL2)) dut_i (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte),
        .osc_tick(osc_tick), .pulse_d1(pulse_d1), .pulse_d2(pulse_d2),
        .conv_result(conv_result), .conv_cycles(conv_cycles),
        .conv_done(conv_done), .conv_ovf(conv_ovf), .conv_off(conv_off));

    function automatic bit hit_at(int i, int per);
        return (per != 0) && (i % per == 0);
    endfunction

    function automatic int cnt_range(int lo, int hi, int per);
        int n = 0;
        for (int i = lo; i <= hi; i++) if (hit_at(i, per)) n++;
        return n;
    endfunction

    function automatic int win_end_at(int start, int n);
        int k = 0;
        for (int i = start; i < start + 100000; i++) begin
            if (hit_at(i, tp)) k++;
            if (k == n) return i;
        end
        return -1;
    endfunction

    function automatic int sat(int v);
        return (v > MASK) ? MASK : v;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit c, input logic [7:0] b);
        @(negedge clk);
        cmd_stb  = c;
        cmd_byte = b;
        osc_tick = hit_at(cyc_i, tp);
        pulse_d1 = hit_at(cyc_i, ap);
        pulse_d2 = hit_at(cyc_i, bp);
        last_idx = cyc_i;
        @(posedge clk);
        #1;
        cyc_i++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 8'h00);
    endtask

    task automatic run_to_done(input int maxn, output int at);
        at = -1;
        for (int k = 0; k < maxn; k++) begin
            step(1'b0, 8'h00);
            if (conv_done) begin
                at = last_idx;
                break;
            end
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int c, c2, c3, c4, e, e1, e2, at, held, ndone;

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 result", conv_result, 0);
        chk("R1 cycles", conv_cycles, 0);
        chk("R1 done/ovf/off", {conv_done, conv_ovf, conv_off}, 0);
        ndone = 0;
        for (int k = 0; k < 40; k++) begin step(1'b0, 8'h00); if (conv_done) ndone++; end
        chk("R1 idle no done", ndone, 0);

        // R2 diode 1, two repeats
        tp = 2; ap = 3; bp = 5;
        step(1'b1, 8'h00); c = last_idx;
        e = win_end_at(c + 1, WIN);
        run_to_done(500, at);
        chk("R2 d1 end cycle", at, e);
        chk("R2 d1 result", conv_result, cnt_range(c + 1, e, ap));
        chk("R2 d1 cycles", conv_cycles, WIN);
        e2 = win_end_at(e + 1, WIN);
        run_to_done(500, at);
        chk("R2 repeat end", at, e2);
        chk("R2 repeat result", conv_result, cnt_range(e + 1, e2, ap));
        held = conv_result;
        idle(5);
        chk("R11 held result", conv_result, held);
        chk("R11 no done", conv_done, 0);

        // R2 diode 2
        step(1'b1, 8'h04); c = last_idx;
        e = win_end_at(c + 1, WIN);
        run_to_done(500, at);
        chk("R2 d2 end cycle", at, e);
        chk("R2 d2 result", conv_result, cnt_range(c + 1, e, bp));

        // R3 differential, negative then positive
        for (int s = 0; s < 2; s++) begin
            ap = (s == 0) ? 7 : 2;
            bp = (s == 0) ? 2 : 9;
            step(1'b1, 8'h08); c = last_idx;
            e1 = win_end_at(c + 1, WIN);
            e2 = win_end_at(e1 + 1, WIN);
            run_to_done(500, at);
            chk("R3 diff end cycle", at, e2);
            chk("R3 diff result", conv_result,
                (cnt_range(e1 + 1, e2, ap) - cnt_range(c + 1, e1, bp)) & MASK);
            chk("R3 diff cycles", conv_cycles, WIN);
        end
        ap = 3; bp = 5;

        // R9 rewrite restarts
        step(1'b1, 8'h04);
        idle(7);
        step(1'b1, 8'h04); c = last_idx;
        run_to_done(500, at);
        chk("R9 rewrite end", at, win_end_at(c + 1, WIN));

        // R12 command on end cycle wins
        step(1'b1, 8'h00); c = last_idx;
        e = win_end_at(c + 1, WIN);
        while (cyc_i < e) step(1'b0, 8'h00);
        step(1'b1, 8'h00);
        idle(1);
        chk("R12 no publish", conv_done, 0);
        run_to_done(500, at);
        chk("R12 new window end", at, win_end_at(e + 1, WIN));

        // R10 unknown codes ignored
        step(1'b1, 8'h00); c = last_idx;
        idle(5);
        step(1'b1, 8'h55);
        idle(2);
        step(1'b1, 8'h3C);
        run_to_done(500, at);
        chk("R10 schedule kept", at, win_end_at(c + 1, WIN));

        // R7 sleep and wake
        step(1'b1, 8'h8C);
        chk("R7 off high", conv_off, 1);
        held = conv_result;
        ndone = 0;
        for (int k = 0; k < 60; k++) begin step(1'b0, 8'h00); if (conv_done) ndone++; end
        chk("R7 no done while off", ndone, 0);
        chk("R7 result held", conv_result, held);
        step(1'b1, 8'h00); c = last_idx;
        chk("R7 woken", conv_off, 0);
        run_to_done(500, at);
        chk("R7 wake conversion end", at, win_end_at(c + 1, WIN));

        // R4 external windows
        tp = 3; ap = 2; bp = 5;
        step(1'b1, 8'h30); c = last_idx;
        chk("R4 opener no publish", conv_done, 0);
        idle(20);
        chk("R6 no ovf on small window", conv_ovf, 0);
        step(1'b1, 8'h30); c2 = last_idx;
        chk("R4 close done", conv_done, 1);
        chk("R4 close result", conv_result, cnt_range(c + 1, c2, ap));
        chk("R4 close cycles", conv_cycles, cnt_range(c + 1, c2, tp));
        idle(13);
        step(1'b1, 8'h34); c3 = last_idx;
        chk("R4 source of window", conv_result, cnt_range(c2 + 1, c3, ap));
        idle(9);
        step(1'b1, 8'h30); c4 = last_idx;
        chk("R4 d2 window result", conv_result, cnt_range(c3 + 1, c4, bp));

        // R5 external differential
        step(1'b1, 8'h38); c = last_idx;
        idle(17);
        step(1'b1, 8'h38); c2 = last_idx;
        chk("R5 d2 phase no publish", conv_done, 0);
        idle(11);
        step(1'b1, 8'h38); c3 = last_idx;
        chk("R5 d1 phase done", conv_done, 1);
        chk("R5 diff result", conv_result,
            (cnt_range(c2 + 1, c3, ap) - cnt_range(c + 1, c2, bp)) & MASK);
        chk("R5 diff cycles", conv_cycles, cnt_range(c2 + 1, c3, tp));

        // R6 saturation
        tp = 1; ap = 1;
        step(1'b1, 8'h30); c = last_idx;
        idle(299);
        chk("R6 ovf sticky", conv_ovf, 1);
        step(1'b1, 8'h30); c2 = last_idx;
        chk("R6 result saturated", conv_result, sat(cnt_range(c + 1, c2, ap)));
        chk("R6 cycles saturated", conv_cycles, sat(cnt_range(c + 1, c2, tp)));
        chk("R6 ovf cleared", conv_ovf, 0);

        // R8 clear
        step(1'b1, 8'h0C);
        chk("R8 result zero", conv_result, 0);
        chk("R8 cycles zero", conv_cycles, 0);
        chk("R8 off low", conv_off, 0);
        ndone = 0;
        for (int k = 0; k < 40; k++) begin step(1'b0, 8'h00); if (conv_done) ndone++; end
        chk("R8 idle after clear", ndone, 0);

        finish_run();
    end
endmodule